// File: doc/BRIEF.md
# SD/MMC Command Path Controller

This block drives the command line of an SD/MMC host. A register-style request carries a command index, a 32-bit argument and four mode flags. The block builds a 48-bit command frame with its CRC7 and shifts it out most significant bit first on a half-duplex CMD line. It then either finishes, captures a 48-bit short or a 136-bit long response and checks its CRC, or waits for a card interrupt request. All sequencing advances only on a one-cycle card-clock enable strobe. That strobe marks each rising edge of the card clock.

The controller is a five-state machine. IDLE enforces a minimum quiet gap and leaves on a tick once a request is held. It goes to PEND when the pending flag was set, and to SEND otherwise. PEND waits for the data path's pending pulse and then moves to SEND. SEND drives the frame for 48 ticks. It then goes to WAIT when a response or an interrupt is expected, and to IDLE otherwise. WAIT has three exits. A 0 start bit moves it to RECEIVE. A timer expiry moves it to IDLE. In interrupt mode, a card interrupt moves it to IDLE. RECEIVE collects the rest of the response and returns to IDLE. Status flags stay set until the next request is accepted.

Top module: `cmd_path_ctrl`

## Requirements
- R1: A command frame is 48 bits, sent MSB first. Bit 47 is 0 and bit 46 is 1. Bits 45:40 hold the index and bits 39:8 hold the argument. Bits 7:1 hold a CRC7 (polynomial x^7+x^3+1, zero initial value) over bits 47:8, and bit 0 is 1.
- R2: `cmd_oe` is high for exactly 48 consecutive ticks per command and low in every other state, including while a response is received. `cmd_o` and `cmd_oe` change only on a tick.
- R3: A command with no response and no interrupt wait returns to IDLE after its last bit and sets `sent`. `sent` is set at the end of every SEND.
- R4: A short response is a 0 start bit followed by 47 more bits, and lands in `resp_o[47:0]` with the upper bits zero. Bits 47:1 are passed through the CRC7. A zero remainder sets `resp_ok`; a non-zero remainder sets `crc_fail`. The two are never set together.
- R5: A long response is 136 bits and lands in `resp_o[135:0]`. Only bits 127:1 are passed through the CRC7. The start bit, the transmission bit and the 6 reserved bits do not affect the result.
- R6: In WAIT with a response expected, 64 ticks of a high line with no start bit set `timeout` and return to IDLE. 63 such ticks do not.
- R7: In interrupt mode the response timer is off. The machine stays in WAIT until `irq_i` is high on a tick, then sets `intr_seen` and returns to IDLE, with `timeout` never set.
- R8: With the pending flag set, the machine holds in PEND without driving the line until `pend_i` has pulsed. It then sends the frame from the next tick.
- R9: Between the end of one SEND and the start of the next, the line is released for at least 8 ticks.
- R10: After reset the machine is in IDLE with `cmd_oe`=0, `busy`=0 and all status flags 0.
- R11: A request is accepted only while `busy` is low, and acceptance clears all status flags. A `req_valid` pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Card-clock rising-edge strobe, one cycle wide |
| req_valid | input | 1 | Request pulse, accepted when not busy |
| req_index | input | 6 | Command index |
| req_arg | input | 32 | Command argument |
| req_resp | input | 1 | A response or interrupt wait follows the command |
| req_long | input | 1 | Response is 136 bits instead of 48 |
| req_intr | input | 1 | Wait for card interrupt; response timer off |
| req_pend | input | 1 | Hold the command until the data path pulses `pend_i` |
| pend_i | input | 1 | Pending release pulse from the data path |
| irq_i | input | 1 | Card interrupt request |
| cmd_i | input | 1 | Sampled CMD line |
| cmd_o | output | 1 | CMD output value |
| cmd_oe | output | 1 | CMD output enable |
| busy | output | 1 | Request held or transfer in progress |
| sent | output | 1 | Command frame fully sent |
| resp_ok | output | 1 | Response received with good CRC |
| crc_fail | output | 1 | Response received with bad CRC |
| timeout | output | 1 | No response start bit within the window |
| intr_seen | output | 1 | Card interrupt ended an interrupt wait |
| resp_o | output | 136 | Received response, right aligned |

## Verification
Two situations are hard to reach from the ports. One is the exact tick on which the response timer expires. The other is holding a command in PEND while a second request arrives. The bench acts as a card that answers on card-clock edges. It releases the line immediately after `sent` and counts ticks from that point. It checks that `timeout` is still clear after 63 silent ticks and set after 64. During the same wait it pulses a second request to show that the request is dropped. For PEND, it idles for many ticks with no line activity before pulsing `pend_i` between ticks. It then decodes the captured frame.

// File: rtl/sdc_cmd_pkg.sv
package sdc_cmd_pkg;

    localparam int SDC_IDX_W   = 6;
    localparam int SDC_ARG_W   = 32;
    localparam int SDC_CRC_W   = 7;
    localparam int SDC_FRAME_W = 48;
    localparam int SDC_LONG_W  = 136;
    localparam int SDC_HDR_W   = 2 + SDC_IDX_W + SDC_ARG_W;
    localparam logic [SDC_CRC_W-1:0] SDC_POLY = 7'h09;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PEND,
        ST_SEND,
        ST_WAIT,
        ST_RECV
    } sdc_state_e;

    // one serial CRC7 step, MSB-first
    function automatic logic [SDC_CRC_W-1:0] crc7_step(input logic [SDC_CRC_W-1:0] c,
                                                        input logic b);
        logic fb;
        fb = c[SDC_CRC_W-1] ^ b;
        return {c[SDC_CRC_W-2:0], 1'b0} ^ (fb ? SDC_POLY : '0);
    endfunction

    // CRC7 over the frame header (start, direction, index, argument)
    function automatic logic [SDC_CRC_W-1:0] crc7_header(input logic [SDC_HDR_W-1:0] d);
        logic [SDC_CRC_W-1:0] c;
        c = '0;
        for (int i = SDC_HDR_W - 1; i >= 0; i--) begin
            c = crc7_step(c, d[i]);
        end
        return c;
    endfunction

endpackage

// File: rtl/sdc_crc7_acc.sv
module sdc_crc7_acc
    import sdc_cmd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 en,
    input  logic                 bit_i,
    output logic [SDC_CRC_W-1:0] crc_o
);

    logic [SDC_CRC_W-1:0] crc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= '0;
        end else if (clr) begin
            crc_q <= '0;
        end else if (en) begin
            crc_q <= crc7_step(crc_q, bit_i);
        end
    end

    assign crc_o = crc_q;

endmodule

// File: rtl/sdc_shift_in.sv
module sdc_shift_in #(
    parameter int W = 136
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         bit_i,
    output logic [W-1:0] data_o
);

    logic [W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (clr) begin
            sh_q <= '0;
        end else if (en) begin
            sh_q <= {sh_q[W-2:0], bit_i};
        end
    end

    assign data_o = sh_q;

endmodule

// File: rtl/sdc_tick_timer.sv
module sdc_tick_timer #(
    parameter int GAP_TICKS = 8,
    parameter int TO_TICKS  = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic gap_clr,
    input  logic gap_run,
    output logic gap_done,
    input  logic to_clr,
    input  logic to_run,
    output logic to_last
);

    localparam int GAP_W = $clog2(GAP_TICKS + 1);
    localparam int TO_W  = $clog2(TO_TICKS);

    logic [GAP_W-1:0] gap_q;
    logic [TO_W-1:0]  to_q;

    // quiet-gap counter, saturating; starts satisfied out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= GAP_W'(GAP_TICKS);
        end else if (gap_clr) begin
            gap_q <= '0;
        end else if (gap_run && tick && (gap_q != GAP_W'(GAP_TICKS))) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // response window counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            to_q <= '0;
        end else if (to_clr) begin
            to_q <= '0;
        end else if (to_run && tick) begin
            to_q <= to_q + 1'b1;
        end
    end

    assign gap_done = (gap_q == GAP_W'(GAP_TICKS));
    assign to_last  = (to_q == TO_W'(TO_TICKS - 1));

endmodule

// File: rtl/cmd_path_ctrl.sv
module cmd_path_ctrl
    import sdc_cmd_pkg::*;
#(
    parameter int GAP_TICKS = 8,
    parameter int TO_TICKS  = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clk_en,
    input  logic                  req_valid,
    input  logic [SDC_IDX_W-1:0]  req_index,
    input  logic [SDC_ARG_W-1:0]  req_arg,
    input  logic                  req_resp,
    input  logic                  req_long,
    input  logic                  req_intr,
    input  logic                  req_pend,
    input  logic                  pend_i,
    input  logic                  irq_i,
    input  logic                  cmd_i,
    output logic                  cmd_o,
    output logic                  cmd_oe,
    output logic                  busy,
    output logic                  sent,
    output logic                  resp_ok,
    output logic                  crc_fail,
    output logic                  timeout,
    output logic                  intr_seen,
    output logic [SDC_LONG_W-1:0] resp_o
);

    localparam int CNT_W     = $clog2(SDC_LONG_W + 1);
    localparam int LONG_SKIP = SDC_LONG_W - 128;  // start, direction, reserved
    localparam logic [CNT_W-1:0] TX_LAST   = CNT_W'(SDC_FRAME_W - 1);
    localparam logic [CNT_W-1:0] SH_LAST   = CNT_W'(SDC_FRAME_W - 1);
    localparam logic [CNT_W-1:0] LG_LAST   = CNT_W'(SDC_LONG_W - 1);
    localparam logic [CNT_W-1:0] SH_CRC_HI = CNT_W'(SDC_FRAME_W - 2);
    localparam logic [CNT_W-1:0] LG_CRC_LO = CNT_W'(LONG_SKIP);
    localparam logic [CNT_W-1:0] LG_CRC_HI = CNT_W'(SDC_LONG_W - 2);

    sdc_state_e state_q, state_d;

    logic                   tick;
    logic                   accept;
    logic                   have_req;
    logic [SDC_FRAME_W-1:0] frame_q;
    logic                   resp_q, long_q, intr_q, pend_q, pend_seen;
    logic [CNT_W-1:0]       bcnt_q;
    logic [CNT_W-1:0]       rx_last;
    logic                   gap_done, to_last;
    logic                   gap_clr, to_clr, to_run;
    logic                   crc_clr, crc_en;
    logic                   sh_en;
    logic [SDC_CRC_W-1:0]   rx_crc;
    logic [SDC_CRC_W-1:0]   hdr_crc;

    assign tick    = clk_en;
    assign busy    = (state_q != ST_IDLE) || have_req;
    assign accept  = req_valid && !busy;
    assign rx_last = long_q ? LG_LAST : SH_LAST;
    assign hdr_crc = crc7_header({2'b01, req_index, req_arg});

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (tick && have_req && gap_done) begin
                    state_d = pend_q ? ST_PEND : ST_SEND;
                end
            end
            ST_PEND: begin
                if (tick && (pend_seen || pend_i)) begin
                    state_d = ST_SEND;
                end
            end
            ST_SEND: begin
                if (tick && (bcnt_q == TX_LAST)) begin
                    state_d = resp_q ? ST_WAIT : ST_IDLE;
                end
            end
            ST_WAIT: begin
                if (tick) begin
                    if (intr_q) begin
                        if (irq_i) begin
                            state_d = ST_IDLE;
                        end
                    end else if (!cmd_i) begin
                        state_d = ST_RECV;
                    end else if (to_last) begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_RECV: begin
                if (tick && (bcnt_q == rx_last)) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- line outputs ----------------
    always_comb begin
        cmd_oe = 1'b0;
        cmd_o  = 1'b1;
        unique case (state_q)
            ST_SEND: begin
                cmd_oe = 1'b1;
                cmd_o  = frame_q[SDC_FRAME_W-1];
            end
            ST_IDLE, ST_PEND, ST_WAIT, ST_RECV: begin
                cmd_oe = 1'b0;
                cmd_o  = 1'b1;
            end
            default: begin
                cmd_oe = 1'b0;
                cmd_o  = 1'b1;
            end
        endcase
    end

    // ---------------- request capture and frame shifter ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_req  <= 1'b0;
            frame_q   <= '0;
            resp_q    <= 1'b0;
            long_q    <= 1'b0;
            intr_q    <= 1'b0;
            pend_q    <= 1'b0;
            pend_seen <= 1'b0;
        end else begin
            if (accept) begin
                have_req  <= 1'b1;
                frame_q   <= {2'b01, req_index, req_arg, hdr_crc, 1'b1};
                resp_q    <= req_resp;
                long_q    <= req_long;
                intr_q    <= req_intr;
                pend_q    <= req_pend;
                pend_seen <= 1'b0;
            end else begin
                if ((state_q == ST_IDLE) && (state_d != ST_IDLE)) begin
                    have_req <= 1'b0;
                end
                if ((state_q == ST_PEND) && pend_i) begin
                    pend_seen <= 1'b1;
                end
                if ((state_q == ST_SEND) && tick) begin
                    frame_q <= {frame_q[SDC_FRAME_W-2:0], 1'b0};
                end
            end
        end
    end

    // ---------------- bit counter ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcnt_q <= '0;
        end else if (tick) begin
            if (state_d != state_q) begin
                bcnt_q <= (state_d == ST_RECV) ? CNT_W'(1) : '0;
            end else if ((state_q == ST_SEND) || (state_q == ST_RECV)) begin
                bcnt_q <= bcnt_q + 1'b1;
            end
        end
    end

    // ---------------- status flags ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sent      <= 1'b0;
            resp_ok   <= 1'b0;
            crc_fail  <= 1'b0;
            timeout   <= 1'b0;
            intr_seen <= 1'b0;
        end else if (accept) begin
            sent      <= 1'b0;
            resp_ok   <= 1'b0;
            crc_fail  <= 1'b0;
            timeout   <= 1'b0;
            intr_seen <= 1'b0;
        end else begin
            if ((state_q == ST_SEND) && (state_d != ST_SEND)) begin
                sent <= 1'b1;
            end
            if ((state_q == ST_WAIT) && (state_d == ST_IDLE)) begin
                if (intr_q) begin
                    intr_seen <= 1'b1;
                end else begin
                    timeout <= 1'b1;
                end
            end
            if ((state_q == ST_RECV) && (state_d == ST_IDLE)) begin
                resp_ok  <= (rx_crc == '0);
                crc_fail <= (rx_crc != '0);
            end
        end
    end

    // ---------------- receive datapath ----------------
    assign crc_clr = (state_q == ST_WAIT);
    assign crc_en  = (state_q == ST_RECV) && tick &&
                     (long_q ? ((bcnt_q >= LG_CRC_LO) && (bcnt_q <= LG_CRC_HI))
                             : (bcnt_q <= SH_CRC_HI));
    assign sh_en   = tick && (((state_q == ST_WAIT) && !intr_q && !cmd_i) ||
                              (state_q == ST_RECV));

    sdc_crc7_acc u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .en    (crc_en),
        .bit_i (cmd_i),
        .crc_o (rx_crc)
    );

    sdc_shift_in #(.W(SDC_LONG_W)) u_resp (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (accept),
        .en     (sh_en),
        .bit_i  (cmd_i),
        .data_o (resp_o)
    );

    // ---------------- timers ----------------
    assign gap_clr = (state_q == ST_SEND) || (state_q == ST_WAIT) || (state_q == ST_RECV);
    assign to_clr  = (state_q != ST_WAIT);
    assign to_run  = (state_q == ST_WAIT) && !intr_q;

    sdc_tick_timer #(
        .GAP_TICKS (GAP_TICKS),
        .TO_TICKS  (TO_TICKS)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .gap_clr  (gap_clr),
        .gap_run  (state_q == ST_IDLE),
        .gap_done (gap_done),
        .to_clr   (to_clr),
        .to_run   (to_run),
        .to_last  (to_last)
    );

endmodule

// File: rtl/sdc_cmd_chk.sv
module sdc_cmd_chk
    import sdc_cmd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       clk_en,
    input logic       cmd_o,
    input logic       cmd_oe,
    input sdc_state_e state,
    input logic       gap_done,
    input logic       sent,
    input logic       timeout,
    input logic       resp_ok,
    input logic       crc_fail,
    input logic       intr_q
);

    p_hold_between_ticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(cmd_o) && $stable(cmd_oe)));

    p_sent_from_send_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sent) |-> ($past(state) == ST_SEND));

    p_result_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(resp_ok && crc_fail));

    p_timeout_from_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> (($past(state) == ST_WAIT) && !$past(intr_q)));

    p_no_timer_in_intr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_WAIT) && intr_q) |=> !timeout);

    p_gap_before_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_oe) |-> $past(gap_done));

endmodule

bind cmd_path_ctrl sdc_cmd_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .cmd_o    (cmd_o),
    .cmd_oe   (cmd_oe),
    .state    (state_q),
    .gap_done (gap_done),
    .sent     (sent),
    .timeout  (timeout),
    .resp_ok  (resp_ok),
    .crc_fail (crc_fail),
    .intr_q   (intr_q)
);

// File: tb/sim_cmd_path_ctrl.sv
`timescale 1ns/1ps
module sim_cmd_path_ctrl;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clk_en = 1'b0;
    logic         req_valid = 1'b0;
    logic [5:0]   req_index = '0;
    logic [31:0]  req_arg = '0;
    logic         req_resp = 1'b0, req_long = 1'b0, req_intr = 1'b0, req_pend = 1'b0;
    logic         pend_i = 1'b0, irq_i = 1'b0, cmd_i = 1'b1;
    logic         cmd_o, cmd_oe, busy, sent, resp_ok, crc_fail, timeout, intr_seen;
    logic [135:0] resp_o;

    int n_chk = 0;
    int n_err = 0;

    logic [47:0] cap = '0;
    int          ncap = 0;
    int          low_run = 0;
    int          last_gap = 0;

    cmd_path_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .req_valid(req_valid),
        .req_index(req_index), .req_arg(req_arg), .req_resp(req_resp),
        .req_long(req_long), .req_intr(req_intr), .req_pend(req_pend),
        .pend_i(pend_i), .irq_i(irq_i), .cmd_i(cmd_i), .cmd_o(cmd_o),
        .cmd_oe(cmd_oe), .busy(busy), .sent(sent), .resp_ok(resp_ok),
        .crc_fail(crc_fail), .timeout(timeout), .intr_seen(intr_seen),
        .resp_o(resp_o)
    );

    initial forever #4 clk = ~clk;

    initial begin
        forever begin
            repeat (3) @(posedge clk);
            clk_en <= 1'b1;
            @(posedge clk);
            clk_en <= 1'b0;
        end
    end

    // line monitor: sample just before each tick
    always @(negedge clk) begin
        if (clk_en) begin
            if (cmd_oe) begin
                cap  = {cap[46:0], cmd_o};
                ncap = ncap + 1;
                if (low_run > 0) last_gap = low_run;
                low_run = 0;
            end else begin
                low_run = low_run + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [135:0] act,
                       input logic [135:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] b_crc(input logic [135:0] d, input int hi, input int lo);
        logic [6:0] c;
        c = '0;
        for (int i = hi; i >= lo; i--) begin
            logic f;
            f = c[6] ^ d[i];
            c = {c[5:0], 1'b0};
            if (f) c = c ^ 7'h09;
        end
        return c;
    endfunction

    function automatic logic [47:0] cmd_frame(input logic [5:0] idx, input logic [31:0] arg);
        logic [47:0] f;
        f = {2'b01, idx, arg, 7'h00, 1'b1};
        f[7:1] = b_crc({88'h0, f}, 47, 8);
        return f;
    endfunction

    task automatic tick_neg();
        do @(negedge clk); while (!clk_en);
    endtask

    task automatic issue(input logic [5:0] idx, input logic [31:0] arg, input bit rsp,
                         input bit lng, input bit intr, input bit pnd);
        @(negedge clk);
        while (busy) @(negedge clk);
        ncap = 0;
        req_index = idx; req_arg = arg; req_resp = rsp;
        req_long = lng; req_intr = intr; req_pend = pnd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_sent();
        int n;
        n = 0;
        @(negedge clk);
        while (!sent && n < 4000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic card_reply(input logic [135:0] fr, input int len, input int dly,
                              output bit oe_seen);
        oe_seen = 1'b0;
        for (int i = 0; i < dly; i++) begin
            tick_neg();
            cmd_i = 1'b1;
        end
        for (int i = len - 1; i >= 0; i--) begin
            tick_neg();
            if (cmd_oe) oe_seen = 1'b1;
            cmd_i = fr[i];
        end
        tick_neg();
        cmd_i = 1'b1;
    endtask

    task automatic t_reset();
        chk(cmd_oe == 1'b0, "R10 oe after reset", 136'(cmd_oe), 136'(0));
        chk(busy == 1'b0, "R10 busy after reset", 136'(busy), 136'(0));
        chk({sent, resp_ok, crc_fail, timeout, intr_seen} == 5'b0, "R10 flags after reset",
            136'({sent, resp_ok, crc_fail, timeout, intr_seen}), 136'(0));
    endtask

    task automatic t_no_resp();
        logic [47:0] e;
        e = cmd_frame(6'd0, 32'h0);
        issue(6'd0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
        wait_sent();
        @(negedge clk);
        chk(ncap == 48, "R2 drive length", 136'(ncap), 136'(48));
        chk(cap == e, "R1 frame CMD0", 136'(cap), 136'(e));
        chk(sent && !busy, "R3 no-response ends in idle", 136'({sent, busy}), 136'(2'b10));
    endtask

    task automatic t_short(input bit bad);
        logic [47:0] e, r;
        bit oe_seen;
        e = cmd_frame(6'd17, 32'h1234_5678);
        r = {2'b00, 6'd17, 32'hCAFE_0001, 7'h00, 1'b1};
        r[7:1] = b_crc({88'h0, r}, 47, 8);
        if (bad) r[3] = ~r[3];
        issue(6'd17, 32'h1234_5678, 1'b1, 1'b0, 1'b0, 1'b0);
        wait_sent();
        chk(cap == e, "R1 frame CMD17", 136'(cap), 136'(e));
        card_reply({88'h0, r}, 48, 2, oe_seen);
        @(negedge clk);
        chk(!oe_seen, "R2 line released during response", 136'(oe_seen), 136'(0));
        chk(resp_o == {88'h0, r}, "R4 short response capture", resp_o, {88'h0, r});
        if (bad)
            chk(crc_fail && !resp_ok, "R4 bad CRC flagged", 136'({resp_ok, crc_fail}), 136'(2'b01));
        else
            chk(resp_ok && !crc_fail, "R4 good CRC accepted", 136'({resp_ok, crc_fail}), 136'(2'b10));
    endtask

    task automatic t_long();
        logic [135:0] r;
        bit oe_seen;
        r = {8'h3F, 32'hDEAD_BEEF, 32'h0123_4567, 32'h89AB_CDEF, 24'hC0FFEE, 7'h00, 1'b1};
        r[7:1] = b_crc(r, 127, 8);
        issue(6'd2, 32'h0, 1'b1, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        chk(!crc_fail && !resp_ok, "R11 flags cleared on accept", 136'({resp_ok, crc_fail}), 136'(0));
        wait_sent();
        card_reply(r, 136, 3, oe_seen);
        @(negedge clk);
        chk(resp_o == r, "R5 long response capture", resp_o, r);
        chk(resp_ok && !crc_fail, "R5 long CRC over 127:1", 136'({resp_ok, crc_fail}), 136'(2'b10));
    endtask

    task automatic t_timeout();
        int nc;
        issue(6'd9, 32'hFFFF_0000, 1'b1, 1'b0, 1'b0, 1'b0);
        wait_sent();
        nc = ncap;
        for (int i = 0; i < 64; i++) begin
            tick_neg();
            if (i == 10) begin
                req_index = 6'd5; req_resp = 1'b0; req_valid = 1'b1;
                @(negedge clk);
                req_valid = 1'b0;
            end
        end
        chk(!timeout, "R6 no timeout after 63 ticks", 136'(timeout), 136'(0));
        tick_neg();
        chk(timeout, "R6 timeout after 64 ticks", 136'(timeout), 136'(1));
        @(negedge clk);
        chk(!busy && ncap == nc, "R11 request while busy ignored", 136'({busy, 8'(ncap - nc)}), 136'(0));
    endtask

    task automatic t_intr();
        issue(6'd40, 32'h0, 1'b1, 1'b0, 1'b1, 1'b0);
        wait_sent();
        for (int i = 0; i < 100; i++) tick_neg();
        chk(!timeout && busy, "R7 timer off in interrupt wait", 136'({timeout, busy}), 136'(2'b01));
        irq_i = 1'b1;
        tick_neg();
        irq_i = 1'b0;
        @(negedge clk);
        chk(intr_seen && !busy && !timeout, "R7 interrupt ends wait",
            136'({intr_seen, busy, timeout}), 136'(3'b100));
    endtask

    task automatic t_pend();
        logic [47:0] e;
        e = cmd_frame(6'd12, 32'h0000_0001);
        issue(6'd12, 32'h0000_0001, 1'b0, 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 30; i++) tick_neg();
        chk(ncap == 0 && busy, "R8 held in pending state", 136'({busy, 8'(ncap)}), 136'({1'b1, 8'h0}));
        @(posedge clk);
        @(negedge clk);
        pend_i = 1'b1;
        @(negedge clk);
        pend_i = 1'b0;
        wait_sent();
        chk(cap == e && ncap == 48, "R8 frame after pending release", 136'(cap), 136'(e));
    endtask

    task automatic t_gap();
        logic [47:0] e;
        e = cmd_frame(6'd7, 32'hA5A5_5A5A);
        issue(6'd7, 32'hA5A5_5A5A, 1'b0, 1'b0, 1'b0, 1'b0);
        wait_sent();
        chk(cap == e, "R1 frame back-to-back", 136'(cap), 136'(e));
        chk(last_gap >= 8, "R9 idle gap between frames", 136'(last_gap), 136'(8));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_no_resp();
        t_short(1'b0);
        t_short(1'b1);
        t_long();
        t_timeout();
        t_intr();
        t_pend();
        t_gap();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule